// File: doc/BRIEF.md
# Machine Cycle State Sequencer

This block paces an 8-bit controller core that runs without a clock prescaler. It runs on a double-rate tick clock, so one tick is one half of an oscillator period. It walks a fixed machine cycle of six states. Each state has two phases, which gives twelve ticks per cycle. From the current position the block derives every timing strobe the core and the external bus need. These are the opcode capture pulse, the second program byte fetch, the program counter advance, the end-of-cycle marker, the address latch strobe and the active-low program store enable.

The core supplies the length of the current opcode (one or two bytes). It also says whether code is being fetched from external memory, whether the current cycle is an external data access, and whether it wants the address latch strobe switched off while code runs from internal memory. All strobes come from decode logic on the registered tick index, so every strobe is valid in the same tick as the state and phase it belongs to.

Top module: `mcyc_sequencer`

## Requirements
- R1: State and phase advance one step per tick, from state 1 phase 1 through state 6 phase 2, then wrap to state 1 phase 1. `state_num` reports 1 to 6 and `phase_two` is 0 in phase 1 and 1 in phase 2.
- R2: A tick with `rst` high moves the sequencer to state 1 phase 1 on that clock edge, and it stays there while `rst` is held.
- R3: `opcode_latch` is high in state 1 phase 2 and in no other tick.
- R4: `byte2_fetch` is high in state 4 phase 2 of every cycle, for one-byte and two-byte opcodes alike, and in no other tick.
- R5: `pc_inc` is high in state 4 phase 2 only when `instr_two_byte` is 1. When `instr_two_byte` is 0 the fetched byte is discarded and `pc_inc` stays low.
- R6: `cycle_end` is high for exactly one tick per cycle, in state 6 phase 2.
- R7: With the bus strobes enabled, `ale` is high in state 1 phase 2, state 2 phase 1, state 4 phase 2 and state 5 phase 1, which gives two pulses per cycle. It is low in every other tick.
- R8: While `ext_data` is 1, `ale` stays low and `psen_n` stays high in every tick.
- R9: With `ext_fetch` 1 and `ext_data` 0, `psen_n` is low from state 2 phase 2 through state 3 phase 2 and from state 5 phase 2 through state 6 phase 2, and high elsewhere. With `ext_fetch` 0, `psen_n` stays high.
- R10: `ale_off` = 1 keeps `ale` low only while `ext_fetch` is 0. While `ext_fetch` is 1, `ale_off` has no effect on `ale`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per oscillator half period |
| rst | input | 1 | Synchronous active-high reset |
| instr_two_byte | input | 1 | 1 = current opcode has a second byte |
| ext_fetch | input | 1 | 1 = program code comes from external memory |
| ext_data | input | 1 | 1 = this cycle is an external data access |
| ale_off | input | 1 | 1 = suppress ALE during internal execution |
| state_num | output | 3 | Current state, 1 to 6 |
| phase_two | output | 1 | 0 = phase 1, 1 = phase 2 |
| opcode_latch | output | 1 | Opcode capture pulse |
| byte2_fetch | output | 1 | Second program byte read pulse |
| pc_inc | output | 1 | Program counter advance pulse |
| cycle_end | output | 1 | End of machine cycle pulse |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store enable, active low |

## Verification
The state and phase move one tick after each clock edge, and a reset written in one tick takes effect at the next edge. The bench model advances its own expected index at every edge, using the reset value present at that edge. Every strobe is a combinational function of that index and the current control inputs, so it is due in the same tick in which those inputs are applied. The bench therefore changes inputs just after the rising edge and compares all outputs at the following falling edge. Random ticks are mixed with directed stretches: held data access, ALE disable with and without external fetch, and a reset in mid-cycle.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int NUM_STATES = 6;
    localparam int TICKS      = 2 * NUM_STATES;
    localparam int IDX_W      = $clog2(TICKS);
    localparam int ST_W       = $clog2(NUM_STATES + 1);

    typedef logic [IDX_W-1:0] tick_t;

    typedef struct packed {
        logic opcode_latch;
        logic byte2_fetch;
        logic pc_inc;
        logic cycle_end;
        logic ale;
        logic psen_n;
    } strobes_t;

    // Tick index of a given state (1-based) and phase (0 = phase 1, 1 = phase 2)
    function automatic tick_t slot(input int st, input int ph);
        return tick_t'((st - 1) * 2 + ph);
    endfunction

    function automatic logic [ST_W-1:0] state_of(input tick_t i);
        return ST_W'(i[IDX_W-1:1]) + ST_W'(1);
    endfunction

endpackage

// File: rtl/mcyc_tick_counter.sv
module mcyc_tick_counter
    import mcyc_pkg::*;
#(
    parameter int TICKS_P = TICKS
) (
    input  logic  clk,
    input  logic  rst,
    output tick_t idx
);
    localparam tick_t LAST = tick_t'(TICKS_P - 1);

    always_ff @(posedge clk) begin
        if (rst)              idx <= '0;
        else if (idx == LAST) idx <= '0;
        else                  idx <= idx + tick_t'(1);
    end

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (idx == LAST) |=> (idx == '0));

    a_r1_bounded: assert property (@(posedge clk) disable iff (rst)
        idx <= LAST);

    always @(posedge clk) begin
        if (rst_d == 1'b1) begin
            a_r2_reset_home: assert (idx == '0);
        end
    end

endmodule

// File: rtl/mcyc_strobe_decode.sv
module mcyc_strobe_decode
    import mcyc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tick_t    idx,
    input  logic     instr_two_byte,
    input  logic     ext_fetch,
    input  logic     ext_data,
    input  logic     ale_off,
    output strobes_t strb
);
    localparam tick_t OPC_SLOT  = slot(1, 1);
    localparam tick_t FETCH2    = slot(4, 1);
    localparam tick_t END_SLOT  = slot(6, 1);
    localparam tick_t ALE_A0    = slot(1, 1);
    localparam tick_t ALE_A1    = slot(2, 0);
    localparam tick_t ALE_B0    = slot(4, 1);
    localparam tick_t ALE_B1    = slot(5, 0);
    localparam tick_t PSEN_A0   = slot(2, 1);
    localparam tick_t PSEN_A1   = slot(3, 1);
    localparam tick_t PSEN_B0   = slot(5, 1);
    localparam tick_t PSEN_B1   = slot(6, 1);

    logic ale_window, psen_window, bus_free, ale_allowed;

    always_comb begin
        ale_window  = (idx >= ALE_A0 && idx <= ALE_A1) ||
                      (idx >= ALE_B0 && idx <= ALE_B1);
        psen_window = (idx >= PSEN_A0 && idx <= PSEN_A1) ||
                      (idx >= PSEN_B0 && idx <= PSEN_B1);
        bus_free    = !ext_data;
        ale_allowed = ext_fetch || !ale_off;

        strb.opcode_latch = (idx == OPC_SLOT);
        strb.byte2_fetch  = (idx == FETCH2);
        strb.pc_inc       = (idx == FETCH2) && instr_two_byte;
        strb.cycle_end    = (idx == END_SLOT);
        strb.ale          = ale_window && bus_free && ale_allowed;
        strb.psen_n       = !(psen_window && bus_free && ext_fetch);
    end

    a_r8_data_quiet: assert property (@(posedge clk) disable iff (rst)
        ext_data |-> (!strb.ale && strb.psen_n));

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strb.opcode_latch, strb.byte2_fetch, strb.cycle_end}));

    a_r5_pc_needs_fetch: assert property (@(posedge clk) disable iff (rst)
        strb.pc_inc |-> strb.byte2_fetch);

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(strb.ale && !strb.psen_n));

endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
    import mcyc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_two_byte,
    input  logic            ext_fetch,
    input  logic            ext_data,
    input  logic            ale_off,
    output logic [ST_W-1:0] state_num,
    output logic            phase_two,
    output logic            opcode_latch,
    output logic            byte2_fetch,
    output logic            pc_inc,
    output logic            cycle_end,
    output logic            ale,
    output logic            psen_n
);
    tick_t    idx;
    strobes_t strb;

    mcyc_tick_counter #(.TICKS_P(TICKS)) u_cnt (
        .clk (clk),
        .rst (rst),
        .idx (idx)
    );

    mcyc_strobe_decode u_dec (
        .clk            (clk),
        .rst            (rst),
        .idx            (idx),
        .instr_two_byte (instr_two_byte),
        .ext_fetch      (ext_fetch),
        .ext_data       (ext_data),
        .ale_off        (ale_off),
        .strb           (strb)
    );

    always_comb begin
        state_num    = state_of(idx);
        phase_two    = idx[0];
        opcode_latch = strb.opcode_latch;
        byte2_fetch  = strb.byte2_fetch;
        pc_inc       = strb.pc_inc;
        cycle_end    = strb.cycle_end;
        ale          = strb.ale;
        psen_n       = strb.psen_n;
    end

    a_r6_end_then_start: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> (state_num == ST_W'(1) && !phase_two));

    a_r7_latch_under_ale: assert property (@(posedge clk) disable iff (rst)
        (opcode_latch && !ext_data && !ale_off) |-> ale);

endmodule

// File: tb/mcyc_sequencer_tb_top.sv
`timescale 1ns/1ps
module mcyc_sequencer_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic two_b = 1'b0, efetch = 1'b0, edata = 1'b0, aoff = 1'b0;
    logic [2:0] state_num;
    logic phase_two, opcode_latch, byte2_fetch, pc_inc, cycle_end, ale, psen_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    int exp_idx = 0;

    always #2 clk = ~clk;   // 250 MHz

    mcyc_sequencer dut_i (
        .clk(clk), .rst(rst), .instr_two_byte(two_b), .ext_fetch(efetch),
        .ext_data(edata), .ale_off(aoff), .state_num(state_num),
        .phase_two(phase_two), .opcode_latch(opcode_latch),
        .byte2_fetch(byte2_fetch), .pc_inc(pc_inc), .cycle_end(cycle_end),
        .ale(ale), .psen_n(psen_n)
    );

    // Reference position model
    always @(posedge clk) begin
        if (rst) exp_idx <= 0;
        else     exp_idx <= (exp_idx == 11) ? 0 : exp_idx + 1;
    end

    function automatic int e_state(int i); return i / 2 + 1; endfunction
    function automatic int e_phase(int i); return i % 2; endfunction

    function automatic bit e_ale(int i, bit ef, bit ed, bit ao);
        int s = e_state(i); int p = e_phase(i);
        bit win = (s == 1 && p == 1) || (s == 2 && p == 0) ||
                  (s == 4 && p == 1) || (s == 5 && p == 0);
        return win && !ed && (ef || !ao);
    endfunction

    function automatic bit e_psen_n(int i, bit ef, bit ed);
        int s = e_state(i); int p = e_phase(i);
        bit win = (s == 2 && p == 1) || (s == 3) || (s == 5 && p == 1) || (s == 6);
        return !(win && ef && !ed);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic check_all();
        int s = e_state(exp_idx);
        int p = e_phase(exp_idx);
        chk(rst ? "R2 state" : "R1 state", state_num, s);
        chk(rst ? "R2 phase" : "R1 phase", phase_two, p);
        chk("R3 opcode_latch", opcode_latch, (s == 1 && p == 1));
        chk("R4 byte2_fetch", byte2_fetch, (s == 4 && p == 1));
        chk("R5 pc_inc", pc_inc, (s == 4 && p == 1 && two_b));
        chk("R6 cycle_end", cycle_end, (s == 6 && p == 1));
        chk(edata ? "R8 ale" : (aoff ? "R10 ale" : "R7 ale"), ale,
            e_ale(exp_idx, efetch, edata, aoff));
        chk(edata ? "R8 psen_n" : "R9 psen_n", psen_n,
            e_psen_n(exp_idx, efetch, edata));
    endtask

    task automatic tick(bit r, bit tb, bit ef, bit ed, bit ao);
        @(posedge clk);
        #1;
        rst = r; two_b = tb; efetch = ef; edata = ed; aoff = ao;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EC0_0A1E));
        // R2: reset holds the home position
        for (int i = 0; i < 5; i++) tick(1, 1, 1, 0, 0);
        // R1/R7/R9: external fetch, two-byte opcodes
        for (int i = 0; i < 36; i++) tick(0, 1, 1, 0, 0);
        // R5: one-byte opcodes, fetch discarded
        for (int i = 0; i < 24; i++) tick(0, 0, 1, 0, 0);
        // R8: external data access held for several cycles
        for (int i = 0; i < 36; i++) tick(0, i[0], 1, 1, 0);
        // R10: ALE disable, internal then external code
        for (int i = 0; i < 24; i++) tick(0, 1, 0, 0, 1);
        for (int i = 0; i < 24; i++) tick(0, 1, 1, 0, 1);
        // R2: reset in the middle of a cycle
        for (int i = 0; i < 7; i++) tick(0, 0, 1, 0, 0);
        tick(1, 0, 1, 0, 0);
        tick(1, 0, 1, 0, 0);
        for (int i = 0; i < 14; i++) tick(0, 1, 1, 0, 0);
        // Random mix
        for (int i = 0; i < 1500; i++) begin
            tick(($urandom % 100) < 2, $urandom % 2, $urandom % 2,
                 ($urandom % 4) == 0, $urandom % 2);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule